// File: doc/BRIEF.md
# Stepped Core-Supply Code Loader

This block turns a requested core clock frequency, given in kHz, into a 12-bit code for an external voltage regulator and delivers that code over a three-wire serial link: a data line, a shift clock and an active-high load strobe. A large change in supply code can pull the rail down far enough to trip the regulator. The block therefore walks from the code it last loaded toward the new target in bounded increments, and it sends one complete serial frame for each increment.

A request is a one-cycle start pulse that carries a frequency and a force flag. With force set, the first frame carries the target code directly. Without force, each frame moves the code by at most one step, and the final frame lands exactly on the target. The block raises busy while it works and pulses done when the frame that reaches the target has been latched. Every serial phase lasts a parameterised number of system clocks, so the link speed can be fitted to the regulator.

Top module: `vreg_step_loader`

## Requirements
- R1: A frequency below 200000 kHz selects target code 0xFFF. A frequency from 200000 to 299999 kHz selects 0xDE5. A frequency of 300000 kHz or more selects 0x325.
- R2: Without force, each frame's code follows from the current code C and the target T. If C + 0x100 < T, the frame carries C + 0x100. If C > T + 0x100, it carries C - 0x100. Otherwise it carries T.
- R3: With force set at start, the first frame carries T. Force affects that first frame only.
- R4: A frame is 12 bits, most significant bit first. Each bit is taken on a rising edge of ser_clk_o. The clock idles low. The load strobe stays low while bits are shifted, and all three serial pins are low when the block is idle.
- R5: The clock high time and the load high time each equal PHASE_CYC system clocks. Between two bits of one frame the clock is low for 2*PHASE_CYC clocks (hold, then setup). Data does not change while the clock is high.
- R6: After the 12th bit the load strobe pulses high once, and the frame's code then becomes the current code. Frames repeat until the current code equals the target, and every request sends at least one frame, even when the current code already equals the target.
- R7: busy_o rises in the cycle after an accepted start. A start that arrives while busy_o is high is ignored, along with its frequency and force flag.
- R8: done_o is high for exactly one cycle, the cycle in which busy_o returns low.
- R9: After reset, busy_o, done_o and all serial pins are low, and the current code is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse |
| freq_khz_i | input | FREQ_W | Requested core frequency in kHz |
| force_i | input | 1 | Send the target code in the first frame |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse when the target code is latched |
| ser_data_o | output | 1 | Serial data, MSB first |
| ser_clk_o | output | 1 | Serial shift clock, idles low |
| ser_load_o | output | 1 | Load strobe, active high |

## Verification
The bench builds the block with PHASE_CYC set to 3 and keeps the default widths, step size, frequency bands and codes. Short phases keep a full walk from 0x000 to 0xFFF, which takes sixteen frames, to a couple of thousand cycles. Many requests therefore fit in one run, including walks in both directions, forced jumps and band-edge frequencies. A phase length above one still exposes off-by-one errors in the phase timer, because the bench measures the clock high time, the clock low time between bits and the strobe high time directly at the pins.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_LOAD
  } phase_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_PICK,
    CT_SEND
  } ctrl_e;

endpackage

// File: rtl/vreg_code_map.sv
module vreg_code_map #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned LO_KHZ  = 200000,
  parameter int unsigned MID_KHZ = 300000,
  parameter logic [CODE_W-1:0] LO_CODE  = 'hFFF,
  parameter logic [CODE_W-1:0] MID_CODE = 'hDE5,
  parameter logic [CODE_W-1:0] HI_CODE  = 'h325
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [FREQ_W-1:0] LO_LIM  = FREQ_W'(LO_KHZ);
  localparam logic [FREQ_W-1:0] MID_LIM = FREQ_W'(MID_KHZ);

  always_comb begin
    if (freq_i < LO_LIM)       code_o = LO_CODE;
    else if (freq_i < MID_LIM) code_o = MID_CODE;
    else                       code_o = HI_CODE;
  end

endmodule

// File: rtl/vreg_step_sel.sv
module vreg_step_sel #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned STEP   = 256
) (
  input  logic [CODE_W-1:0] cur_i,
  input  logic [CODE_W-1:0] tgt_i,
  input  logic              force_i,
  output logic [CODE_W-1:0] next_o
);

  // one extra bit so target + step cannot wrap
  localparam int unsigned EXT_W = CODE_W + 1;
  localparam logic [EXT_W-1:0]  STEP_X = EXT_W'(STEP);
  localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP);

  logic [EXT_W-1:0] cur_x, tgt_x;

  assign cur_x = {1'b0, cur_i};
  assign tgt_x = {1'b0, tgt_i};

  always_comb begin
    if (force_i)                    next_o = tgt_i;
    else if (cur_x + STEP_X < tgt_x) next_o = cur_i + STEP_C;
    else if (cur_x > tgt_x + STEP_X) next_o = cur_i - STEP_C;
    else                             next_o = tgt_i;
  end

endmodule

// File: rtl/vreg_frame_tx.sv
module vreg_frame_tx
  import vreg_pkg::*;
#(
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned PHASE_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              sload_o,
  output logic              done_o
);

  localparam int unsigned TMR_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int unsigned BIT_W = $clog2(CODE_W);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PHASE_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CODE_W - 1);

  phase_e            phase_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CODE_W-1:0] sh_q;
  logic              tmr_end;

  assign tmr_end = (tmr_q == TMR_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (launch_i) begin
        phase_q <= PH_SETUP;
        sh_q    <= code_i;
        bit_q   <= '0;
        tmr_q   <= '0;
      end
    end else if (!tmr_end) begin
      tmr_q <= tmr_q + 1'b1;
    end else begin
      tmr_q <= '0;
      unique case (phase_q)
        PH_SETUP: phase_q <= PH_HIGH;
        PH_HIGH:  phase_q <= PH_LOW;
        PH_LOW: begin
          if (bit_q == BIT_LAST) begin
            phase_q <= PH_LOAD;
          end else begin
            bit_q   <= bit_q + 1'b1;
            sh_q    <= {sh_q[CODE_W-2:0], 1'b0};
            phase_q <= PH_SETUP;
          end
        end
        PH_LOAD:  phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign sclk_o  = (phase_q == PH_HIGH);
  assign sload_o = (phase_q == PH_LOAD);
  assign sdata_o = sh_q[CODE_W-1] &
                   ((phase_q == PH_SETUP) || (phase_q == PH_HIGH) || (phase_q == PH_LOW));
  assign done_o  = (phase_q == PH_LOAD) && tmr_end;

endmodule

// File: rtl/vreg_step_loader.sv
module vreg_step_loader
  import vreg_pkg::*;
#(
  parameter int unsigned FREQ_W    = 32,
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned STEP      = 256,
  parameter int unsigned LO_KHZ    = 200000,
  parameter int unsigned MID_KHZ   = 300000,
  parameter logic [CODE_W-1:0] LO_CODE  = 'hFFF,
  parameter logic [CODE_W-1:0] MID_CODE = 'hDE5,
  parameter logic [CODE_W-1:0] HI_CODE  = 'h325,
  parameter int unsigned PHASE_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_khz_i,
  input  logic              force_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              ser_load_o
);

  ctrl_e             ctrl_q;
  logic [CODE_W-1:0] tgt_q, cur_q, frame_q;
  logic              force_q, done_q;
  logic [CODE_W-1:0] map_code, nxt_code;
  logic              tx_launch, tx_done;

  vreg_code_map #(
    .FREQ_W  (FREQ_W),
    .CODE_W  (CODE_W),
    .LO_KHZ  (LO_KHZ),
    .MID_KHZ (MID_KHZ),
    .LO_CODE (LO_CODE),
    .MID_CODE(MID_CODE),
    .HI_CODE (HI_CODE)
  ) i_map (
    .freq_i(freq_khz_i),
    .code_o(map_code)
  );

  vreg_step_sel #(
    .CODE_W(CODE_W),
    .STEP  (STEP)
  ) i_step (
    .cur_i  (cur_q),
    .tgt_i  (tgt_q),
    .force_i(force_q),
    .next_o (nxt_code)
  );

  assign tx_launch = (ctrl_q == CT_PICK);

  vreg_frame_tx #(
    .CODE_W   (CODE_W),
    .PHASE_CYC(PHASE_CYC)
  ) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(tx_launch),
    .code_i  (nxt_code),
    .sdata_o (ser_data_o),
    .sclk_o  (ser_clk_o),
    .sload_o (ser_load_o),
    .done_o  (tx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CT_IDLE;
      tgt_q   <= '0;
      cur_q   <= '0;
      frame_q <= '0;
      force_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ctrl_q)
        CT_IDLE: begin
          if (start_i) begin
            tgt_q   <= map_code;
            force_q <= force_i;
            ctrl_q  <= CT_PICK;
          end
        end
        CT_PICK: begin
          frame_q <= nxt_code;
          force_q <= 1'b0;
          ctrl_q  <= CT_SEND;
        end
        CT_SEND: begin
          if (tx_done) begin
            cur_q <= frame_q;
            if (frame_q == tgt_q) begin
              done_q <= 1'b1;
              ctrl_q <= CT_IDLE;
            end else begin
              ctrl_q <= CT_PICK;
            end
          end
        end
        default: ctrl_q <= CT_IDLE;
      endcase
    end
  end

  assign busy_o = (ctrl_q != CT_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/vreg_step_loader_chk.sv
module vreg_step_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic ser_data_o,
  input logic ser_clk_o,
  input logic ser_load_o
);

  a_r4_load_excl_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ser_load_o && ser_clk_o));

  a_r4_idle_pins_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ser_clk_o && !ser_load_o && !ser_data_o));

  a_r5_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind vreg_step_loader vreg_step_loader_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ser_data_o(ser_data_o),
  .ser_clk_o (ser_clk_o),
  .ser_load_o(ser_load_o)
);

// File: tb/test_vreg_step_loader.sv
module test_vreg_step_loader;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 3;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freq = '0;
  logic        frc = 1'b0;
  logic        busy, done, sdata, sclk, sload;

  always #(CLK_PERIOD/2) clk = ~clk;

  vreg_step_loader #(.PHASE_CYC(P)) i_vreg_step_loader (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .freq_khz_i(freq),
    .force_i   (frc),
    .busy_o    (busy),
    .done_o    (done),
    .ser_data_o(sdata),
    .ser_clk_o (sclk),
    .ser_load_o(sload)
  );

  int vectors = 0;
  int fails   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_map(input int f);
    if (f < 200000) return 'hFFF;
    if (f < 300000) return 'hDE5;
    return 'h325;
  endfunction

  function automatic int ref_step(input int c, input int t);
    if (c < t - 256) return c + 256;
    if (c > t + 256) return c - 256;
    return t;
  endfunction

  // pin monitor: decodes frames and measures phase widths
  int got[64];
  int ngot = 0;
  int nbits = 0;
  int acc = 0;
  int hi_run = 0, lo_run = 0, ld_run = 0;
  logic p_sclk = 0, p_sload = 0, p_sdata = 0, p_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !p_sclk) begin
        check(!sload, "R4 load low at shift", int'(sload), 0);
        if (nbits >= 1 && nbits <= 11)
          check(lo_run == 2*P, "R5 low time between bits", lo_run, 2*P);
        acc = ((acc << 1) | int'(sdata)) & 'hFFF;
        nbits++;
        hi_run = 1;
      end else if (sclk) begin
        hi_run++;
        check(sdata == p_sdata, "R5 data stable while clock high", int'(sdata), int'(p_sdata));
      end
      if (!sclk && p_sclk) begin
        check(hi_run == P, "R5 clock high time", hi_run, P);
        lo_run = 1;
      end else if (!sclk) begin
        lo_run++;
      end
      if (sload && !p_sload) begin
        check(nbits == 12, "R4 bits per frame", nbits, 12);
        if (ngot < 64) got[ngot] = acc;
        ngot++;
        nbits = 0;
        ld_run = 1;
      end else if (sload) begin
        ld_run++;
      end
      if (!sload && p_sload) check(ld_run == P, "R5 load high time", ld_run, P);
      if (done) begin
        check(!p_done, "R8 done single cycle", int'(p_done), 0);
        check(!busy, "R8 busy low with done", int'(busy), 0);
      end
    end
    p_sclk = sclk; p_sload = sload; p_sdata = sdata; p_done = done;
  end

  int model_cur = 0;

  task automatic do_req(input int f, input bit fc, input bit poke);
    int exp_q[64];
    int n = 0;
    int t = ref_map(f);
    int c = model_cur;
    bit ff = fc;
    do begin
      int nx = ff ? t : ref_step(c, t);
      ff = 0;
      exp_q[n] = nx;
      n++;
      c = nx;
    end while (c != t);
    ngot = 0;
    @(negedge clk);
    freq = f; frc = fc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R7 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      freq = 50000; frc = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0; frc = 1'b0;
      check(busy, "R7 still busy after ignored start", int'(busy), 1);
    end
    while (!done) @(negedge clk);
    check(ngot == n, "R6 frame count", ngot, n);
    for (int i = 0; i < n && i < ngot && i < 64; i++) begin
      if (i == 0 && fc) check(got[i] == exp_q[i], "R3 forced first frame", got[i], exp_q[i]);
      else              check(got[i] == exp_q[i], "R2 stepped frame code", got[i], exp_q[i]);
    end
    if (ngot >= 1 && ngot <= 64)
      check(got[ngot-1] == t, "R1 final code matches band", got[ngot-1], t);
    model_cur = t;
    @(negedge clk);
    check(!busy && !done, "R8 idle after done", int'({busy, done}), 0);
  endtask

  initial begin
    int bnd[4] = '{199999, 200000, 299999, 300000};
    int unsigned seed0 = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    check(!busy && !done && !sdata && !sclk && !sload, "R9 outputs in reset",
          int'({busy, done, sdata, sclk, sload}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !sdata && !sclk && !sload, "R9 outputs after reset",
          int'({busy, done, sdata, sclk, sload}), 0);
    // R9: from code 0 the first unforced frame must be 0x100
    do_req(350000, 1'b0, 1'b0);
    check(got[0] == 'h100, "R9 current code starts at zero", got[0], 'h100);
    do_req(100000, 1'b1, 1'b0);   // R3 single jump 0x325 -> 0xFFF
    check(ngot == 1, "R3 force gives one frame", ngot, 1);
    do_req(250000, 1'b0, 1'b1);   // R7 start poked while busy
    do_req(250000, 1'b0, 1'b0);   // R6 already at target: one frame
    check(ngot == 1, "R6 one frame when at target", ngot, 1);
    for (int i = 0; i < 4; i++) do_req(bnd[i], 1'b0, 1'b0);
    for (int i = 0; i < 25; i++) begin
      int f;
      int b = $urandom % 4;
      if (b == 0)      f = $urandom % 200000;
      else if (b == 1) f = 200000 + $urandom % 100000;
      else if (b == 2) f = 300000 + $urandom % 700000;
      else             f = bnd[$urandom % 4];
      do_req(f, ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    if (seed0 == 32'hFFFF_FFFF) $display("seed note");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule